// File: doc/BRIEF.md
# Carry-Save Best-Match Detector

This block sits at the end of a block-matching motion search. It holds the smallest matching distance found so far and the motion vector that produced it. For every new candidate it decides whether that candidate is worse than the stored best. The distance accumulator upstream produces a sum vector S and a carry vector C, and the distance is S + 2·C. The block keeps its stored best in that same redundant pair. It never resolves either distance to binary.

The comparison adds the inverted stored pair to the candidate pair with one 4:2 compression stage, so no carry-propagate adder or subtracter is used. A single carry-lookahead chain then produces only the top carry-out. That bit is the "candidate is worse" flag. It is valid in the same cycle as the inputs, so it can also serve as an early-abort signal while a distance is still being accumulated.

A search-start pulse resets the stored best to the largest representable distance. The first candidate compared after it is therefore always taken. A tie replaces the stored best.

Top module: `csbm_detect`

## Requirements
- R1: After reset the best motion vector output is 0 and the stored best equals the largest distance, 3·(2^W−1). A candidate with S and C both all ones therefore gives `worse_o` = 0.
- R2: `worse_o` is 1 in the same cycle exactly when the candidate distance (cand_s + 2·cand_c) is strictly greater than the effective stored best. The effective stored best is the largest distance while `start_i` is high, and the stored distance otherwise.
- R3: A cycle with `cmp_valid_i` = 1 and `worse_o` = 0 stores the candidate pair. `best_mv_o` equals that cycle's `cand_mv_i` after the next rising edge.
- R4: A cycle with `cmp_valid_i` = 1 and `worse_o` = 1 leaves both the stored pair and `best_mv_o` unchanged.
- R5: A candidate whose distance equals the stored best replaces it, even when its S/C split differs from the stored split.
- R6: `start_i` resets the stored best to the largest distance and `best_mv_o` to 0. When `start_i` and `cmp_valid_i` are both high in one cycle, the candidate is taken unconditionally.
- R7: `abort_o` = `part_valid_i` AND `worse_o`. Asserting `part_valid_i` never changes the stored best or `best_mv_o`.
- R8: With `cmp_valid_i` and `start_i` both low, the stored best and `best_mv_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Search start: clears the stored best to the maximum |
| cmp_valid_i | input | 1 | Final-distance compare strobe |
| part_valid_i | input | 1 | Partial distance present; enables `abort_o` |
| cand_s_i | input | W | Candidate sum vector |
| cand_c_i | input | W | Candidate carry vector (weight 2) |
| cand_mv_i | input | MVW | Candidate motion vector |
| worse_o | output | 1 | Candidate distance strictly greater than the best |
| abort_o | output | 1 | Partial distance already exceeds the best |
| best_mv_o | output | MVW | Motion vector of the stored best |

## Verification
`worse_o` and `abort_o` are combinational and are due in the same cycle as the candidate. `best_mv_o` changes one rising edge after a compare or start strobe. The bench drives inputs on the falling edge and samples one nanosecond later. At that point it checks the comparison outputs against the candidate just driven. It also checks `best_mv_o` against the model state as of the previous rising edge, and only then advances its model. Comparison against a binary-resolved model covers random traffic, equal-distance ties with different S/C splits, and strobe overlaps.

// File: rtl/csbm_pkg.sv
package csbm_pkg;
    localparam int DEF_DIST_W = 8;
    localparam int DEF_MV_W   = 12;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_TAKE  = 2'd1,
        UPD_CLEAR = 2'd2
    } upd_e;
endpackage

// File: rtl/csbm_cs_compare.sv
module csbm_cs_compare #(
    parameter int W = 8
) (
    input  logic [W-1:0] new_s,
    input  logic [W-1:0] new_c,
    input  logic [W-1:0] ref_s,
    input  logic [W-1:0] ref_c,
    output logic         new_gt
);
    // K bits hold any distance S + 2C; L bits hold the full check sum.
    localparam int K = W + 2;
    localparam int L = K + 2;

    logic [L-1:0] op_a, op_b, op_c, op_d;
    logic [L-1:0] s1, m1, c1, s2, m2, c2;
    logic         cy;

    // Inverted stored pair (K-bit complements); the doubling is wiring.
    assign op_a = {2'b00, ~{2'b00, ref_s}};
    assign op_b = {2'b00, ~{1'b0, ref_c, 1'b0}};
    assign op_c = {4'b0000, new_s};
    assign op_d = {3'b000, new_c, 1'b0};

    always_comb begin
        // 4:2 compression as two 3:2 rows; the +1 enters the free LSB.
        s1 = op_a ^ op_b ^ op_c;
        m1 = (op_a & op_b) | (op_a & op_c) | (op_b & op_c);
        c1 = {m1[L-2:0], 1'b1};
        s2 = s1 ^ c1 ^ op_d;
        m2 = (s1 & c1) | (s1 & op_d) | (c1 & op_d);
        c2 = {m2[L-2:0], 1'b0};
        // Generate/propagate chain: only the carry into the top bit.
        cy = 1'b0;
        for (int i = 0; i < L - 1; i++) begin
            cy = (s2[i] & c2[i]) | ((s2[i] ^ c2[i]) & cy);
        end
        new_gt = s2[L-1] ^ c2[L-1] ^ cy;
    end
endmodule

// File: rtl/csbm_upd_ctrl.sv
module csbm_upd_ctrl
    import csbm_pkg::*;
(
    input  logic start,
    input  logic cmp_valid,
    input  logic worse,
    output upd_e upd
);
    always_comb begin
        if (cmp_valid && !worse) upd = UPD_TAKE;
        else if (start)          upd = UPD_CLEAR;
        else                     upd = UPD_HOLD;
    end
endmodule

// File: rtl/csbm_detect.sv
module csbm_detect
    import csbm_pkg::*;
#(
    parameter int W   = DEF_DIST_W,
    parameter int MVW = DEF_MV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           cmp_valid_i,
    input  logic           part_valid_i,
    input  logic [W-1:0]   cand_s_i,
    input  logic [W-1:0]   cand_c_i,
    input  logic [MVW-1:0] cand_mv_i,
    output logic           worse_o,
    output logic           abort_o,
    output logic [MVW-1:0] best_mv_o
);
    typedef struct packed {
        logic [W-1:0]   s;
        logic [W-1:0]   c;
        logic [MVW-1:0] mv;
    } best_t;

    best_t        st_d, st_q;
    logic [W-1:0] eff_s, eff_c;
    logic         worse;
    upd_e         upd;

    // Start forces the maximum so the same-cycle candidate always wins.
    assign eff_s = start_i ? {W{1'b1}} : st_q.s;
    assign eff_c = start_i ? {W{1'b1}} : st_q.c;

    csbm_cs_compare #(.W(W)) u_cmp (
        .new_s (cand_s_i),
        .new_c (cand_c_i),
        .ref_s (eff_s),
        .ref_c (eff_c),
        .new_gt(worse)
    );

    csbm_upd_ctrl u_ctrl (
        .start    (start_i),
        .cmp_valid(cmp_valid_i),
        .worse    (worse),
        .upd      (upd)
    );

    always_comb begin
        st_d = st_q;
        case (upd)
            UPD_TAKE:  st_d = '{s: cand_s_i, c: cand_c_i, mv: cand_mv_i};
            UPD_CLEAR: st_d = '{s: {W{1'b1}}, c: {W{1'b1}}, mv: '0};
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s: {W{1'b1}}, c: {W{1'b1}}, mv: '0};
        else        st_q <= st_d;
    end

    assign worse_o   = worse;
    assign abort_o   = part_valid_i & worse;
    assign best_mv_o = st_q.mv;

    // R2: the carry-out flag agrees with a binary magnitude comparison
    always_comb begin
        if (rst_n) begin
            a_r2_flag_vs_binary: assert (worse ==
                (({2'b00, cand_s_i} + {1'b0, cand_c_i, 1'b0}) >
                 ({2'b00, eff_s} + {1'b0, eff_c, 1'b0})))
                else $error("R2 carry-save compare disagrees with binary");
        end
    end

    a_r3_take_on_win: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && !worse_o) |=> (best_mv_o == $past(cand_mv_i)));

    a_r4_keep_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && worse_o && !start_i) |=> $stable(best_mv_o));

    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cmp_valid_i) |=> (best_mv_o == '0));

    a_r7_abort_needs_partial: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (part_valid_i && worse_o));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid_i && !start_i) |=> $stable(best_mv_o));
endmodule

// File: tb/sim_csbm_detect.sv
`timescale 1ns/1ps
module sim_csbm_detect;
    localparam int W    = 8;
    localparam int MVW  = 12;
    localparam int DMAX = 3 * ((1 << W) - 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0, cmp_valid_i = 1'b0, part_valid_i = 1'b0;
    logic [W-1:0]   cand_s_i = '0, cand_c_i = '0;
    logic [MVW-1:0] cand_mv_i = '0;
    logic           worse_o, abort_o;
    logic [MVW-1:0] best_mv_o;

    int n_cmp = 0, n_bad = 0;
    int ref_best = DMAX;
    int ref_mv = 0;

    always #2.5 clk = ~clk;

    csbm_detect #(.W(W), .MVW(MVW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_valid_i(cmp_valid_i),
        .part_valid_i(part_valid_i), .cand_s_i(cand_s_i), .cand_c_i(cand_c_i),
        .cand_mv_i(cand_mv_i), .worse_o(worse_o), .abort_o(abort_o),
        .best_mv_o(best_mv_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare 1 ns later, advance model.
    task automatic cyc(input int s, input int c, input int mv, input bit st,
                       input bit cv, input bit pv, input string tag);
        int eff, dn;
        bit gt;
        @(negedge clk);
        cand_s_i = W'(s); cand_c_i = W'(c); cand_mv_i = MVW'(mv);
        start_i = st; cmp_valid_i = cv; part_valid_i = pv;
        #1;
        eff = st ? DMAX : ref_best;
        dn  = s + 2 * c;
        gt  = dn > eff;
        check({tag, " worse_o"}, int'(worse_o), int'(gt));
        check({tag, " abort_o (R7)"}, int'(abort_o), int'(pv && gt));
        check({tag, " best_mv_o"}, int'(best_mv_o), ref_mv);
        if (cv && !gt) begin
            ref_best = dn; ref_mv = mv;
        end else if (st) begin
            ref_best = DMAX; ref_mv = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s, c, d, mv;
        repeat (3) @(negedge clk);
        #1;
        check("R1 best_mv_o in reset", int'(best_mv_o), 0);
        rst_n = 1'b1;
        // R1: stored best is the maximum, so an all-ones candidate is not worse
        cyc(255, 255, 1, 0, 0, 0, "R1");
        // R6: start together with a maximal compare takes it
        cyc(255, 255, 77, 1, 1, 0, "R6");
        cyc(0, 0, 5, 0, 0, 0, "R8");
        cyc(10, 3, 6, 0, 1, 0, "R3");
        cyc(20, 3, 7, 0, 1, 1, "R4 R7");
        cyc(0, 200, 8, 0, 0, 1, "R7");
        // R6: start alone clears, then any candidate wins
        cyc(0, 0, 9, 1, 0, 0, "R6");
        cyc(255, 255, 300, 0, 1, 0, "R6");
        for (int k = 0; k < 600; k++) begin
            cyc($urandom_range(255), $urandom_range(255), $urandom_range(4095),
                ($urandom_range(40) == 0), ($urandom_range(2) != 0),
                $urandom_range(1), "R2 R3 R4 R7 R8");
            // R5: tie with a different split of the stored distance
            if (k % 25 == 0 && ref_best < DMAX) begin
                d = ref_best;
                for (int cc = 0; cc < 256; cc++) begin
                    s = d - 2 * cc;
                    if (s >= 0 && s < 256 && (s % 3) != (d % 3 + k) % 3) begin
                        c = cc;
                        break;
                    end
                end
                if (s < 0 || s > 255) begin
                    c = d / 2; s = d - 2 * c;
                end
                mv = $urandom_range(4095);
                cyc(s, c, mv, 0, 1, 0, "R5");
                cyc(0, 0, 0, 0, 0, 0, "R5");
                check("R5 tie replaced", int'(best_mv_o), mv);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule